// File: doc/BRIEF.md
# PWM Force-Out Output Selector

This block decides what each channel pair of a PWM submodule drives toward the dead-time stage. Each pair can carry the generated PWM waveform, its complement, a software-held level, or an alternate signal supplied from outside. Software writes the wanted choice into a pending select field at any time. The choice only reaches the holding flops when a force-out strobe occurs, so a whole set of changes is staged first and then applied at once.

The strobe for each submodule comes from one of eight event sources through a 3-bit source select. Local sources let one submodule switch on its own. The master sources, taken from submodule 0, and the two external sources let every submodule switch on the same clock edge. The two external event inputs are asynchronous. Each is synchronized and edge-detected before it is used. A parameter sets how many submodules are instanced side by side.

Top module: `pwm_force_sel`

## Requirements
- R1: After reset the held select code of every pair is 0, so each output equals its live PWM input.
- R2: A change of the pending select code, a source select or any input other than the chosen strobe leaves the held code, and therefore the output encoding, unchanged.
- R3: The source select picks the strobe as follows. 0 is the local software force, 1 the master force, 2 the local reload, 3 the master reload, 4 the local sync, 5 the master sync, 6 the external sync and 7 the external force.
- R4: Held code encoding: 0 gives the PWM input, 1 the inverted PWM input, 2 the software level bit, 3 the external alternate signal. Pair A uses alternate input A and pair B uses alternate input B.
- R5: On a rising edge where the chosen strobe is high, both pending codes of that submodule are captured. The output shows the new selection immediately after that edge.
- R6: The master force, master reload and master sync are the local software force, reload and sync of submodule 0. Any submodule, submodule 0 included, can use them, and all submodules using one master strobe switch on the same edge.
- R7: When an external event input rises, submodules using it switch on the third rising clock edge after the rise. An input held high produces only one event.
- R8: The output is combinational on the live PWM, level and alternate inputs. After a capture, a change of the selected input appears at the output with no clock delay.
- R9: A strobe source that is not selected has no effect on the held codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_force | input | N_SUB | Per-submodule software force pulse, one cycle |
| reload | input | N_SUB | Per-submodule reload event |
| sync | input | N_SUB | Per-submodule sync event |
| src_sel | input | 3*N_SUB | Strobe source select, 3 bits per submodule |
| sel_a | input | 2*N_SUB | Pending select code for pair A |
| sel_b | input | 2*N_SUB | Pending select code for pair B |
| lvl_a | input | N_SUB | Software level for pair A |
| lvl_b | input | N_SUB | Software level for pair B |
| pwm_a | input | N_SUB | Generated PWM for pair A |
| pwm_b | input | N_SUB | Generated PWM for pair B |
| alt_a | input | N_SUB | External alternate signal A |
| alt_b | input | N_SUB | External alternate signal B |
| x_sync_in | input | 1 | Asynchronous external sync event |
| x_force_in | input | 1 | Asynchronous external force event |
| out_a | output | N_SUB | Selected signal for pair A to dead-time logic |
| out_b | output | N_SUB | Selected signal for pair B to dead-time logic |

## Verification
A new pending code and the strobe that captures it can arrive in the same cycle. The bench drives both on one falling edge and expects the code present at the next rising edge to be taken, not the older one. A master strobe can also coincide with local events in other submodules. The bench pulses submodule 0's software force while a second submodule's local force is high but unselected, and it checks that only the master-selected submodules switch, all on that one edge.

// File: rtl/pwmfo_pkg.sv
// Shared encodings for the force-out selector.
// Assumes: source and output codes are fixed by software convention.
package pwmfo_pkg;
    localparam int SRC_W  = 3;
    localparam int NUM_SRC = 1 << SRC_W;
    localparam int OSEL_W = 2;

    typedef enum logic [SRC_W-1:0] {
        SRC_SW   = 3'd0,
        SRC_MSW  = 3'd1,
        SRC_RLD  = 3'd2,
        SRC_MRLD = 3'd3,
        SRC_SYN  = 3'd4,
        SRC_MSYN = 3'd5,
        SRC_XSYN = 3'd6,
        SRC_XFRC = 3'd7
    } fo_src_e;

    typedef enum logic [OSEL_W-1:0] {
        OSEL_PWM = 2'd0,
        OSEL_INV = 2'd1,
        OSEL_LVL = 2'd2,
        OSEL_ALT = 2'd3
    } osel_e;

    // Picks the live signal for one pair from its held code.
    function automatic logic osel_pick(logic [OSEL_W-1:0] code, logic pwm, logic lvl, logic alt);
        case (code)
            OSEL_PWM: osel_pick = pwm;
            OSEL_INV: osel_pick = ~pwm;
            OSEL_LVL: osel_pick = lvl;
            default:  osel_pick = alt;
        endcase
    endfunction
endpackage

// File: rtl/fo_edge_sync.sv
// Synchronizes an asynchronous event line and emits a one-cycle pulse on
// its rising edge. Assumes: input stays stable for at least two clocks.
module fo_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_p
);
    localparam int LEN = STAGES + 1;
    logic [LEN-1:0] shreg;

    // Shift the input through the synchronizer and a history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[LEN-2:0], async_in};
    end

    assign rise_p = shreg[STAGES-1] & ~shreg[STAGES];
endmodule

// File: rtl/fo_out_pair.sv
// Holds the select code of one channel pair and steers the chosen signal
// to the output. Assumes: capture is a single-cycle strobe.
module fo_out_pair
    import pwmfo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [OSEL_W-1:0] code_nxt,
    input  logic              pwm,
    input  logic              lvl,
    input  logic              alt,
    output logic [OSEL_W-1:0] code_q,
    output logic              sig_out
);
    // Load the pending code on a strobe; default to plain PWM.
    always_ff @(posedge clk) begin
        if (!rst_n)   code_q <= OSEL_PWM;
        else if (cap) code_q <= code_nxt;
    end

    // Combinational steering on live inputs.
    always_comb sig_out = osel_pick(code_q, pwm, lvl, alt);
endmodule

// File: rtl/fo_submod.sv
// One submodule: strobe source mux plus a generated set of channel pairs.
// Assumes: all strobe inputs are already synchronous single-cycle pulses.
module fo_submod
    import pwmfo_pkg::*;
#(
    parameter int NPAIR = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    l_force,
    input  logic                    l_reload,
    input  logic                    l_sync,
    input  logic                    m_force,
    input  logic                    m_reload,
    input  logic                    m_sync,
    input  logic                    x_sync,
    input  logic                    x_force,
    input  logic [SRC_W-1:0]        src,
    input  logic [NPAIR*OSEL_W-1:0] code_nxt,
    input  logic [NPAIR-1:0]        pwm,
    input  logic [NPAIR-1:0]        lvl,
    input  logic [NPAIR-1:0]        alt,
    output logic [NPAIR*OSEL_W-1:0] code_q,
    output logic [NPAIR-1:0]        sig_out,
    output logic                    fire
);
    logic [NUM_SRC-1:0] events;

    // Gather the eight candidate strobes in select order.
    always_comb begin
        events           = '0;
        events[SRC_SW]   = l_force;
        events[SRC_MSW]  = m_force;
        events[SRC_RLD]  = l_reload;
        events[SRC_MRLD] = m_reload;
        events[SRC_SYN]  = l_sync;
        events[SRC_MSYN] = m_sync;
        events[SRC_XSYN] = x_sync;
        events[SRC_XFRC] = x_force;
    end

    assign fire = events[src];

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        fo_out_pair u_pair (
            .clk      (clk),
            .rst_n    (rst_n),
            .cap      (fire),
            .code_nxt (code_nxt[p*OSEL_W +: OSEL_W]),
            .pwm      (pwm[p]),
            .lvl      (lvl[p]),
            .alt      (alt[p]),
            .code_q   (code_q[p*OSEL_W +: OSEL_W]),
            .sig_out  (sig_out[p])
        );
    end
endmodule

// File: rtl/pwm_force_sel.sv
// Top: N_SUB submodules with two channel pairs each. Submodule 0's local
// force, reload and sync are shared as master strobes; external events
// are synchronized once and fanned out. Assumes rst_n is synchronous.
module pwm_force_sel
    import pwmfo_pkg::*;
#(
    parameter int N_SUB   = 3,
    parameter int SYNC_FF = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SUB-1:0]        sw_force,
    input  logic [N_SUB-1:0]        reload,
    input  logic [N_SUB-1:0]        sync,
    input  logic [N_SUB*SRC_W-1:0]  src_sel,
    input  logic [N_SUB*OSEL_W-1:0] sel_a,
    input  logic [N_SUB*OSEL_W-1:0] sel_b,
    input  logic [N_SUB-1:0]        lvl_a,
    input  logic [N_SUB-1:0]        lvl_b,
    input  logic [N_SUB-1:0]        pwm_a,
    input  logic [N_SUB-1:0]        pwm_b,
    input  logic [N_SUB-1:0]        alt_a,
    input  logic [N_SUB-1:0]        alt_b,
    input  logic                    x_sync_in,
    input  logic                    x_force_in,
    output logic [N_SUB-1:0]        out_a,
    output logic [N_SUB-1:0]        out_b
);
    localparam int NPAIR = 2;

    logic                    x_sync_p;
    logic                    x_force_p;
    logic [N_SUB-1:0]        fire;
    logic [N_SUB*OSEL_W-1:0] hold_a;
    logic [N_SUB*OSEL_W-1:0] hold_b;

    fo_edge_sync #(.STAGES(SYNC_FF)) u_xsync (
        .clk (clk), .rst_n (rst_n), .async_in (x_sync_in),  .rise_p (x_sync_p)
    );
    fo_edge_sync #(.STAGES(SYNC_FF)) u_xforce (
        .clk (clk), .rst_n (rst_n), .async_in (x_force_in), .rise_p (x_force_p)
    );

    for (genvar i = 0; i < N_SUB; i++) begin : g_sub
        logic [NPAIR*OSEL_W-1:0] codes_q;
        logic [NPAIR-1:0]        sigs;

        fo_submod #(.NPAIR(NPAIR)) u_sub (
            .clk      (clk),
            .rst_n    (rst_n),
            .l_force  (sw_force[i]),
            .l_reload (reload[i]),
            .l_sync   (sync[i]),
            .m_force  (sw_force[0]),
            .m_reload (reload[0]),
            .m_sync   (sync[0]),
            .x_sync   (x_sync_p),
            .x_force  (x_force_p),
            .src      (src_sel[i*SRC_W +: SRC_W]),
            .code_nxt ({sel_b[i*OSEL_W +: OSEL_W], sel_a[i*OSEL_W +: OSEL_W]}),
            .pwm      ({pwm_b[i], pwm_a[i]}),
            .lvl      ({lvl_b[i], lvl_a[i]}),
            .alt      ({alt_b[i], alt_a[i]}),
            .code_q   (codes_q),
            .sig_out  (sigs),
            .fire     (fire[i])
        );

        assign hold_a[i*OSEL_W +: OSEL_W] = codes_q[OSEL_W-1:0];
        assign hold_b[i*OSEL_W +: OSEL_W] = codes_q[2*OSEL_W-1:OSEL_W];
        assign out_a[i] = sigs[0];
        assign out_b[i] = sigs[1];
    end
endmodule

// File: rtl/pwm_force_sel_chk.sv
// Assertion checker for pwm_force_sel, bound to every instance.
module pwm_force_sel_chk #(
    parameter int N_SUB = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N_SUB*2-1:0]   sel_a,
    input logic [N_SUB*2-1:0]   sel_b,
    input logic [N_SUB*2-1:0]   hold_a,
    input logic [N_SUB*2-1:0]   hold_b,
    input logic [N_SUB-1:0]     fire,
    input logic [N_SUB-1:0]     pwm_a,
    input logic [N_SUB-1:0]     pwm_b,
    input logic [N_SUB-1:0]     out_a,
    input logic [N_SUB-1:0]     out_b,
    input logic                 x_sync_p,
    input logic                 x_force_p
);
    for (genvar i = 0; i < N_SUB; i++) begin : g_chk
        a_r1_reset_code: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> (hold_a[i*2 +: 2] == 2'd0 && hold_b[i*2 +: 2] == 2'd0));
        a_r2_keep_a: assert property (@(posedge clk) disable iff (!rst_n)
            !fire[i] |=> $stable(hold_a[i*2 +: 2]));
        a_r2_keep_b: assert property (@(posedge clk) disable iff (!rst_n)
            !fire[i] |=> $stable(hold_b[i*2 +: 2]));
        a_r5_capture_a: assert property (@(posedge clk) disable iff (!rst_n)
            fire[i] |=> hold_a[i*2 +: 2] == $past(sel_a[i*2 +: 2]));
        a_r5_capture_b: assert property (@(posedge clk) disable iff (!rst_n)
            fire[i] |=> hold_b[i*2 +: 2] == $past(sel_b[i*2 +: 2]));
        a_r8_pass_a: assert property (@(posedge clk) disable iff (!rst_n)
            hold_a[i*2 +: 2] == 2'd0 |-> out_a[i] == pwm_a[i]);
        a_r8_pass_b: assert property (@(posedge clk) disable iff (!rst_n)
            hold_b[i*2 +: 2] == 2'd1 |-> out_b[i] == !pwm_b[i]);
    end

    a_r7_one_sync: assert property (@(posedge clk) disable iff (!rst_n)
        x_sync_p |=> !x_sync_p);
    a_r7_one_force: assert property (@(posedge clk) disable iff (!rst_n)
        x_force_p |=> !x_force_p);
endmodule

bind pwm_force_sel pwm_force_sel_chk #(.N_SUB(N_SUB)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_a     (sel_a),
    .sel_b     (sel_b),
    .hold_a    (hold_a),
    .hold_b    (hold_b),
    .fire      (fire),
    .pwm_a     (pwm_a),
    .pwm_b     (pwm_b),
    .out_a     (out_a),
    .out_b     (out_b),
    .x_sync_p  (x_sync_p),
    .x_force_p (x_force_p)
);

// File: tb/pwm_force_sel_test.sv
`timescale 1ns/1ps
module pwm_force_sel_test;
    localparam int N = 3;

    logic clk = 0;
    logic rst_n = 0;
    logic [N-1:0]   sw_force = '0, reload = '0, sync = '0;
    logic [N*3-1:0] src_sel = '0;
    logic [N*2-1:0] sel_a = '0, sel_b = '0;
    logic [N-1:0]   lvl_a = '0, lvl_b = '0, pwm_a = '0, pwm_b = '0, alt_a = '0, alt_b = '0;
    logic           x_sync_in = 0, x_force_in = 0;
    logic [N-1:0]   out_a, out_b;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pwm_force_sel #(.N_SUB(N)) uut (
        .clk(clk), .rst_n(rst_n), .sw_force(sw_force), .reload(reload), .sync(sync),
        .src_sel(src_sel), .sel_a(sel_a), .sel_b(sel_b), .lvl_a(lvl_a), .lvl_b(lvl_b),
        .pwm_a(pwm_a), .pwm_b(pwm_b), .alt_a(alt_a), .alt_b(alt_b),
        .x_sync_in(x_sync_in), .x_force_in(x_force_in), .out_a(out_a), .out_b(out_b)
    );

    function automatic logic expect_sig(int code, logic pwm, logic lvl, logic alt);
        case (code)
            0: return pwm;
            1: return ~pwm;
            2: return lvl;
            default: return alt;
        endcase
    endfunction

    task automatic check(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Pulse one strobe bit of kind k (0 sw,1 reload,2 sync) for one cycle.
    task automatic pulse(int kind, int s);
        case (kind)
            0: sw_force[s] = 1'b1;
            1: reload[s] = 1'b1;
            default: sync[s] = 1'b1;
        endcase
        tick();
        sw_force = '0; reload = '0; sync = '0;
    endtask

    // Force all submodules back to code 0 via their own software force.
    task automatic clear_all();
        sel_a = '0; sel_b = '0; src_sel = '0;
        sw_force = '1;
        tick();
        sw_force = '0;
    endtask

    task automatic t_reset();
        for (int v = 0; v < 2; v++) begin
            pwm_a = {N{v[0]}}; pwm_b = {N{~v[0]}};
            #1;
            for (int s = 0; s < N; s++) begin
                check("R1 out_a", out_a[s], pwm_a[s]);
                check("R1 out_b", out_b[s], pwm_b[s]);
            end
        end
    endtask

    task automatic t_prestage();
        sel_a[1:0] = 2'd1; sel_b[1:0] = 2'd2; lvl_b[0] = 1'b1; pwm_a[0] = 1'b0; pwm_b[0] = 1'b0;
        src_sel[2:0] = 3'd0;
        tick(); tick();
        check("R2 pending a", out_a[0], 1'b0);
        check("R2 pending b", out_b[0], 1'b0);
        pulse(0, 0);
        check("R5 capture a", out_a[0], 1'b1);
        check("R5 capture b", out_b[0], 1'b1);
        sel_a[1:0] = 2'd0;
        tick();
        check("R2 after", out_a[0], 1'b1);
        clear_all();
    endtask

    task automatic t_encoding();
        for (int c = 0; c < 4; c++) begin
            sel_a[3:2] = 2'(c); sel_b[3:2] = 2'(3 - c);
            src_sel[5:3] = 3'd0;
            pulse(0, 1);
            for (int pat = 0; pat < 8; pat++) begin
                pwm_a[1] = pat[0]; pwm_b[1] = pat[0];
                lvl_a[1] = pat[1]; lvl_b[1] = ~pat[1];
                alt_a[1] = pat[2]; alt_b[1] = ~pat[2];
                #1;
                check("R4 R8 pair a", out_a[1], expect_sig(c, pwm_a[1], lvl_a[1], alt_a[1]));
                check("R4 R8 pair b", out_b[1], expect_sig(3 - c, pwm_b[1], lvl_b[1], alt_b[1]));
            end
        end
        pwm_a = '0; pwm_b = '0; lvl_a = '0; lvl_b = '0; alt_a = '0; alt_b = '0;
        clear_all();
    endtask

    // Sources 0..5 on submodule 1; kind/submodule derived from code.
    task automatic t_source_map();
        lvl_a[1] = 1'b1;
        for (int k = 0; k < 6; k++) begin
            int kind = k / 2;
            int who  = (k % 2 == 0) ? 1 : 0;
            src_sel[5:3] = 3'(k);
            sel_a[3:2] = 2'd2;
            for (int other = 0; other < 3; other++) begin
                if (other != kind) begin
                    pulse(other, 1);
                    pulse(other, 0);
                end
            end
            check("R9 unselected", out_a[1], 1'b0);
            pulse(kind, who);
            check("R3 selected source", out_a[1], 1'b1);
            sel_a[3:2] = 2'd0;
            pulse(kind, who);
            check("R3 back to pwm", out_a[1], 1'b0);
        end
        lvl_a = '0;
        clear_all();
    endtask

    task automatic t_master();
        lvl_a = '1;
        src_sel = {3'd1, 3'd1, 3'd0};
        sel_a = {2'd2, 2'd2, 2'd2};
        src_sel[2:0] = 3'd1;
        sw_force[1] = 1'b1;
        tick();
        sw_force = '0;
        for (int s = 0; s < N; s++) check("R6 no master yet", out_a[s], 1'b0);
        sw_force[0] = 1'b1; sw_force[2] = 1'b1;
        sel_a[5:4] = 2'd2;
        tick();
        sw_force = '0;
        for (int s = 0; s < N; s++) check("R6 same edge", out_a[s], 1'b1);
        lvl_a = '0;
        clear_all();
    endtask

    task automatic t_external();
        alt_a = '1;
        src_sel = {3'd7, 3'd6, 3'd0};
        sel_a = {2'd3, 2'd3, 2'd0};
        x_sync_in = 1'b1; x_force_in = 1'b1;
        tick();
        check("R7 edge1 s1", out_a[1], 1'b0);
        tick();
        check("R7 edge2 s1", out_a[1], 1'b0);
        check("R7 edge2 s2", out_a[2], 1'b0);
        tick();
        check("R7 edge3 s1", out_a[1], 1'b1);
        check("R7 edge3 s2", out_a[2], 1'b1);
        check("R9 s0 untouched", out_a[0], 1'b0);
        sel_a = '0;
        for (int w = 0; w < 5; w++) tick();
        check("R7 single event s1", out_a[1], 1'b1);
        check("R7 single event s2", out_a[2], 1'b1);
        x_sync_in = 1'b0; x_force_in = 1'b0;
        for (int w = 0; w < 4; w++) tick();
        check("R7 fall no event", out_a[1], 1'b1);
        alt_a = '0;
        clear_all();
    endtask

    // Pending code and strobe in the same cycle: new code wins.
    task automatic t_same_cycle();
        lvl_b[2] = 1'b1;
        src_sel[8:6] = 3'd0;
        sel_b[5:4] = 2'd2;
        sw_force[2] = 1'b1;
        tick();
        sw_force = '0;
        check("R5 same cycle", out_b[2], 1'b1);
        lvl_b = '0;
        clear_all();
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_prestage();
        t_encoding();
        t_source_map();
        t_master();
        t_external();
        t_same_cycle();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule